// File: doc/BRIEF.md
# Receive Acceptance Filter and Object Update Engine

Once a received frame's identifier, format bit, remote flag and length code are complete, this block walks the message-object store from object 0 upward. It reads one object at a time through a plain synchronous RAM port and tests whether the object accepts the frame. A valid object with the right direction accepts the frame when its identifier and format bit agree with the frame, with the bits it masks out ignored. The first accepting object ends the walk, so the lowest index always wins.

What happens to the accepting object depends on the frame. A data frame is stored whole and the object's flags are updated. A remote frame does one of three things, chosen by the send object's configuration: it raises the object's send request, it is silently dropped, or only its header is stored. The updated object goes back in one whole-word write. A one-cycle done strobe then reports whether a match was found and at which index.

Top module: `rxAcceptFilter`

## Requirements
- R1: After reset, `scanDone`, `matchHit`, `busy`, `ramRdEn` and `ramWrEn` are 0 and `matchIdx` is 0.
- R2: On `hdrValid` while idle, the block reads objects at indices 0, 1, 2 … in ascending order, one read per object, and stops at the first accepting object. That object's index appears on `matchIdx` with `matchHit`=1 during the single cycle `scanDone` is high. The object word is the packed record `msgObj_t` of package `rxAccPkg`, and the RAM returns read data one cycle after `ramRdEn`.
- R3: An object with `msgVal`=0 never accepts. An object accepts a data frame (`rxRtr`=0) only if `dir`=0, and a remote frame (`rxRtr`=1) only if `dir`=1.
- R4: With `uMask`=1, only identifier bits whose `mask` bit is 1 are compared. The `xtd` bit must equal `rxIde` unless `uMask`=1 and `mXtd`=0.
- R5: For a standard frame (`rxIde`=0), only identifier bits 28..18 are compared, and a stored identifier has bits 17..0 written as 0.
- R6: On a data-frame match, the object gets the received identifier, `xtd`=`rxIde`, `dlc` and all 64 data bits, with `newDat`=1 and `txRqst`=0. Its other fields are unchanged except as R7 and R8 say.
- R7: A store into an object whose `newDat` was already 1 sets `msgLst`. A store never clears `msgLst`.
- R8: A store sets `intPnd` when the object's `rxIE`=1. It leaves `intPnd` unchanged when `rxIE`=0.
- R9: A remote frame matching an object with `rmtEn`=1 sets only `txRqst` to 1. Every other field is written back unchanged.
- R10: A remote frame matching an object with `rmtEn`=0 and `uMask`=0 is dropped. No RAM write occurs, and the done strobe still reports the hit and its index.
- R11: A remote frame matching an object with `rmtEn`=0 and `uMask`=1 stores the identifier, `xtd` and `dlc`, sets `newDat`, clears `txRqst` and leaves the data bytes unchanged. R7 and R8 apply to this store as well.
- R12: When no object accepts, all objects are read, no write occurs, and `scanDone` pulses with `matchHit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdrValid | input | 1 | One-cycle pulse: header and payload inputs are valid |
| rxId | input | 29 | Received identifier, standard identifiers in bits 28..18 |
| rxIde | input | 1 | 1 for an extended frame |
| rxRtr | input | 1 | 1 for a remote frame |
| rxDlc | input | 4 | Received length code |
| rxData | input | 64 | Received payload |
| busy | output | 1 | Scan in progress |
| ramRdEn | output | 1 | Object read request |
| ramWrEn | output | 1 | Object write request |
| ramAddr | output | IDX_W | Object index for read or write |
| ramWrData | output | OBJ_W | Object word to write |
| ramRdData | input | OBJ_W | Object word read, one cycle after ramRdEn |
| scanDone | output | 1 | One-cycle end-of-scan strobe |
| matchHit | output | 1 | A match was found in the last scan |
| matchIdx | output | IDX_W | Index of the matching object |

## Verification
A wrong comparison or a wrong scan order shows up as a wrong `matchHit`/`matchIdx` on the very done strobe that ends that scan. This takes at most two cycles per object plus three. A wrong store rule corrupts only the matched word, and the corruption is visible in the store right after the write that precedes the done strobe. A dropped remote frame or a miss is caught by comparing the whole store against its state before the scan.

// File: rtl/rxAccPkg.sv
package rxAccPkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic              msgVal;
    logic              uMask;
    logic              newDat;
    logic              eob;
    logic              dir;
    logic              rmtEn;
    logic              rxIE;
    logic              txIE;
    logic              intPnd;
    logic              msgLst;
    logic              txRqst;
    logic              xtd;
    logic              mXtd;
    logic [ID_W-1:0]   id;
    logic [ID_W-1:0]   mask;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } msgObj_t;

  localparam int OBJ_W = $bits(msgObj_t);

  typedef struct packed {
    logic capHdr;
    logic loadObj;
    logic wrObj;
  } dpCtl_t;
endpackage

// File: rtl/acceptMatch.sv
module acceptMatch
  import rxAccPkg::*;
(
  input  msgObj_t         obj,
  input  logic [ID_W-1:0] rxId,
  input  logic            rxIde,
  input  logic            rxRtr,
  output logic            hit
);
  localparam logic [ID_W-1:0] STD_WIN = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  logic [ID_W-1:0] careBits;
  logic            idOk;
  logic            xtdOk;

  always_comb begin
    careBits = (obj.uMask ? obj.mask : {ID_W{1'b1}}) &
               (rxIde ? {ID_W{1'b1}} : STD_WIN);
    idOk     = ((obj.id ^ rxId) & careBits) == '0;
    xtdOk    = (obj.xtd == rxIde) || (obj.uMask && !obj.mXtd);
    hit      = obj.msgVal && (obj.dir == rxRtr) && idOk && xtdOk;
  end
endmodule

// File: rtl/accFilterDp.sv
module accFilterDp
  import rxAccPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [ID_W-1:0]   rxId,
  input  logic              rxIde,
  input  logic              rxRtr,
  input  logic [DLC_W-1:0]  rxDlc,
  input  logic [DATA_W-1:0] rxData,
  input  logic [OBJ_W-1:0]  ramRdData,
  output logic              hitNow,
  output logic              writeNeeded,
  output logic [OBJ_W-1:0]  ramWrData
);
  logic [ID_W-1:0]   hId;
  logic              hIde;
  logic              hRtr;
  logic [DLC_W-1:0]  hDlc;
  logic [DATA_W-1:0] hData;
  msgObj_t           objQ;
  msgObj_t           rdObj;
  msgObj_t           newObj;
  logic [ID_W-1:0]   storeId;

  assign rdObj = msgObj_t'(ramRdData);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hId   <= '0;
      hIde  <= 1'b0;
      hRtr  <= 1'b0;
      hDlc  <= '0;
      hData <= '0;
    end else if (ctl.capHdr) begin
      hId   <= rxId;
      hIde  <= rxIde;
      hRtr  <= rxRtr;
      hDlc  <= rxDlc;
      hData <= rxData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           objQ <= '0;
    else if (ctl.loadObj) objQ <= rdObj;
  end

  acceptMatch u_match (
    .obj   (rdObj),
    .rxId  (hId),
    .rxIde (hIde),
    .rxRtr (hRtr),
    .hit   (hitNow)
  );

  assign writeNeeded = !(hRtr && !rdObj.rmtEn && !rdObj.uMask);

  always_comb begin
    storeId = hIde ? hId : {hId[ID_W-1 -: STD_W], {(ID_W-STD_W){1'b0}}};
    newObj  = objQ;
    if (hRtr && objQ.rmtEn) begin
      newObj.txRqst = 1'b1;
    end else begin
      newObj.id     = storeId;
      newObj.xtd    = hIde;
      newObj.dlc    = hDlc;
      if (!hRtr) newObj.data = hData;
      newObj.msgLst = objQ.msgLst | objQ.newDat;
      newObj.intPnd = objQ.intPnd | objQ.rxIE;
      newObj.newDat = 1'b1;
      newObj.txRqst = 1'b0;
    end
  end

  assign ramWrData = OBJ_W'(newObj);

  // R9
  rmt_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wrObj && hRtr && objQ.rmtEn) |->
      (newObj.txRqst && newObj.id == objQ.id && newObj.data == objQ.data &&
       newObj.newDat == objQ.newDat && newObj.dlc == objQ.dlc));

  // R5
  std_id_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wrObj && !hIde && !(hRtr && objQ.rmtEn)) |->
      (newObj.id[ID_W-STD_W-1:0] == '0));
endmodule

// File: rtl/accFilterCtrl.sv
module accFilterCtrl
  import rxAccPkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdrValid,
  input  logic             hitNow,
  input  logic             writeNeeded,
  output dpCtl_t           ctl,
  output logic             ramRdEn,
  output logic             ramWrEn,
  output logic [IDX_W-1:0] ramAddr,
  output logic             scanDone,
  output logic             matchHit,
  output logic [IDX_W-1:0] matchIdx,
  output logic             busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OBJ - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CMP, S_WR, S_DONE} state_t;
  state_t          state;
  state_t          stateNxt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] prevAddr;
  logic             haveRd;

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE: if (hdrValid) stateNxt = S_RD;
      S_RD:   stateNxt = S_CMP;
      S_CMP: begin
        if (hitNow)             stateNxt = writeNeeded ? S_WR : S_DONE;
        else if (idx == LAST_IDX) stateNxt = S_DONE;
        else                    stateNxt = S_RD;
      end
      S_WR:   stateNxt = S_DONE;
      S_DONE: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      matchHit <= 1'b0;
      matchIdx <= '0;
    end else if (ctl.capHdr) begin
      idx      <= '0;
      matchHit <= 1'b0;
      matchIdx <= '0;
    end else if (state == S_CMP) begin
      if (hitNow) begin
        matchHit <= 1'b1;
        matchIdx <= idx;
      end else if (idx != LAST_IDX) begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  always_comb begin
    ctl.capHdr  = (state == S_IDLE) && hdrValid;
    ctl.loadObj = (state == S_CMP);
    ctl.wrObj   = (state == S_WR);
  end

  assign ramRdEn  = (state == S_RD);
  assign ramWrEn  = (state == S_WR);
  assign ramAddr  = idx;
  assign scanDone = (state == S_DONE);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haveRd   <= 1'b0;
      prevAddr <= '0;
    end else if (ctl.capHdr) begin
      haveRd   <= 1'b0;
    end else if (ramRdEn) begin
      haveRd   <= 1'b1;
      prevAddr <= ramAddr;
    end
  end

  // R2
  scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramRdEn && haveRd) |-> (ramAddr == prevAddr + IDX_W'(1)));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scanDone |=> !scanDone);

  // R6
  wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramWrEn |=> (scanDone && matchHit));

  // R12
  miss_no_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scanDone && !matchHit) |-> (matchIdx == '0 && haveRd && prevAddr == LAST_IDX));
endmodule

// File: rtl/rxAcceptFilter.sv
module rxAcceptFilter
  import rxAccPkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdrValid,
  input  logic [ID_W-1:0]   rxId,
  input  logic              rxIde,
  input  logic              rxRtr,
  input  logic [DLC_W-1:0]  rxDlc,
  input  logic [DATA_W-1:0] rxData,
  output logic              busy,
  output logic              ramRdEn,
  output logic              ramWrEn,
  output logic [IDX_W-1:0]  ramAddr,
  output logic [OBJ_W-1:0]  ramWrData,
  input  logic [OBJ_W-1:0]  ramRdData,
  output logic              scanDone,
  output logic              matchHit,
  output logic [IDX_W-1:0]  matchIdx
);
  dpCtl_t ctl;
  logic   hitNow;
  logic   writeNeeded;

  accFilterCtrl #(.NUM_OBJ(NUM_OBJ)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdrValid    (hdrValid),
    .hitNow      (hitNow),
    .writeNeeded (writeNeeded),
    .ctl         (ctl),
    .ramRdEn     (ramRdEn),
    .ramWrEn     (ramWrEn),
    .ramAddr     (ramAddr),
    .scanDone    (scanDone),
    .matchHit    (matchHit),
    .matchIdx    (matchIdx),
    .busy        (busy)
  );

  accFilterDp u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .rxId        (rxId),
    .rxIde       (rxIde),
    .rxRtr       (rxRtr),
    .rxDlc       (rxDlc),
    .rxData      (rxData),
    .ramRdData   (ramRdData),
    .hitNow      (hitNow),
    .writeNeeded (writeNeeded),
    .ramWrData   (ramWrData)
  );

  msgObj_t lastRd;
  msgObj_t wrObjView;
  logic    rdPend;
  assign wrObjView = msgObj_t'(ramWrData);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPend <= 1'b0;
      lastRd <= '0;
    end else begin
      rdPend <= ramRdEn;
      if (rdPend) lastRd <= msgObj_t'(ramRdData);
    end
  end

  // R7
  msglst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramWrEn && lastRd.msgLst) |-> wrObjView.msgLst);

  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramRdEn && ramWrEn));
endmodule

// File: tb/rxAcceptFilter_tb.sv
`timescale 1ns/1ps
module rxAcceptFilter_tb;
  import rxAccPkg::*;

  localparam int NUM_OBJ = 16;
  localparam int IDX_W   = $clog2(NUM_OBJ);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hdrValid = 1'b0;
  logic [ID_W-1:0]   rxId = '0;
  logic              rxIde = 1'b0;
  logic              rxRtr = 1'b0;
  logic [DLC_W-1:0]  rxDlc = '0;
  logic [DATA_W-1:0] rxData = '0;
  logic              busy, ramRdEn, ramWrEn, scanDone, matchHit;
  logic [IDX_W-1:0]  ramAddr, matchIdx;
  logic [OBJ_W-1:0]  ramWrData;
  logic [OBJ_W-1:0]  ramRdData;

  logic              tbWe = 1'b0;
  logic [IDX_W-1:0]  tbAddr = '0;
  msgObj_t           tbData = '0;
  msgObj_t           mem [NUM_OBJ];
  msgObj_t           snap [NUM_OBJ];

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rxAcceptFilter #(.NUM_OBJ(NUM_OBJ)) u_dut (
    .clk(clk), .rst_n(rst_n), .hdrValid(hdrValid), .rxId(rxId), .rxIde(rxIde),
    .rxRtr(rxRtr), .rxDlc(rxDlc), .rxData(rxData), .busy(busy),
    .ramRdEn(ramRdEn), .ramWrEn(ramWrEn), .ramAddr(ramAddr),
    .ramWrData(ramWrData), .ramRdData(ramRdData), .scanDone(scanDone),
    .matchHit(matchHit), .matchIdx(matchIdx)
  );

  always_ff @(posedge clk) begin
    if (tbWe)         mem[tbAddr]  <= tbData;
    else if (ramWrEn) mem[ramAddr] <= msgObj_t'(ramWrData);
    if (ramRdEn)      ramRdData    <= OBJ_W'(mem[ramAddr]);
  end

  task automatic check(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic msgObj_t mk(input logic dir, input logic rmtEn,
      input logic uMask, input logic xtd, input logic mXtd,
      input logic [ID_W-1:0] id, input logic [ID_W-1:0] mask, input logic rxIE);
    msgObj_t o = '0;
    o.msgVal = 1'b1; o.dir = dir; o.rmtEn = rmtEn; o.uMask = uMask;
    o.xtd = xtd; o.mXtd = mXtd; o.id = id; o.mask = mask; o.rxIE = rxIE;
    return o;
  endfunction

  function automatic logic [ID_W-1:0] stdId(input logic [10:0] v);
    return {v, 18'h0};
  endfunction

  task automatic writeObj(input int i, input msgObj_t o);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = IDX_W'(i); tbData = o;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic loadAll();
    msgObj_t o;
    for (int i = 0; i < NUM_OBJ; i++) writeObj(i, '0);
    o = mk(0, 0, 0, 0, 0, stdId(11'h7FF), '0, 0); o.msgVal = 1'b0; writeObj(0, o);
    o = mk(0, 0, 0, 0, 0, stdId(11'h123), '0, 1); o.txRqst = 1'b1; writeObj(1, o);
    writeObj(2, mk(0, 0, 0, 0, 0, stdId(11'h123), '0, 1));
    writeObj(3, mk(0, 0, 0, 1, 0, 29'h0ABCDE12, '0, 0));
    writeObj(4, mk(0, 0, 1, 0, 0, stdId(11'h300), stdId(11'h700), 0));
    o = mk(1, 1, 0, 0, 0, stdId(11'h345), '0, 0); o.dlc = 4'd2; o.data = 64'h5555; writeObj(5, o);
    writeObj(6, mk(1, 0, 0, 0, 0, stdId(11'h346), '0, 0));
    o = mk(1, 0, 1, 0, 1, stdId(11'h347), {ID_W{1'b1}}, 0);
    o.txRqst = 1'b1; o.data = 64'hAAAA_BBBB_CCCC_DDDD; writeObj(7, o);
    writeObj(8, mk(0, 0, 1, 1, 1, 29'h0ABCDE12, 29'h1FFFFFFE, 0));
  endtask

  task automatic runScan(input logic [ID_W-1:0] id, input logic ide, input logic rtr,
                         input logic [DLC_W-1:0] dlc, input logic [DATA_W-1:0] dat);
    int t = 0;
    @(negedge clk);
    rxId = id; rxIde = ide; rxRtr = rtr; rxDlc = dlc; rxData = dat; hdrValid = 1'b1;
    @(negedge clk);
    hdrValid = 1'b0; rxData = '0; rxId = '0;
    while (!scanDone && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(scanDone, "R2 scan completes", 256'(scanDone), 256'(1));
  endtask

  task automatic takeSnap();
    for (int i = 0; i < NUM_OBJ; i++) snap[i] = mem[i];
  endtask

  task automatic checkSnap(input string tag);
    bit same = 1'b1;
    for (int i = 0; i < NUM_OBJ; i++) if (mem[i] != snap[i]) same = 1'b0;
    check(same, tag, 256'(same), 256'(1));
  endtask

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            ide;
    logic            rtr;
    logic            hit;
    logic [3:0]      idx;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{{11'h123, 18'h0},     1'b0, 1'b0, 1'b1, 4'd1},  // R2 lowest of 1,2; R3 skip invalid 0
    '{{11'h123, 18'h0},     1'b0, 1'b1, 1'b0, 4'd0},  // R3 remote needs dir=1
    '{29'h0ABCDE12,         1'b1, 1'b0, 1'b1, 4'd3},  // R4 xtd must match, obj3 before 4
    '{29'h0ABCDE13,         1'b1, 1'b0, 1'b1, 4'd8},  // R4 masked low bit
    '{29'h0C000001,         1'b1, 1'b0, 1'b1, 4'd4},  // R4 mXtd=0 ignores format
    '{{11'h355, 18'h0},     1'b0, 1'b0, 1'b1, 4'd4},  // R4 group mask
    '{{11'h345, 18'h0},     1'b0, 1'b1, 1'b1, 4'd5},  // R3 remote to send object
    '{{11'h346, 18'h0},     1'b0, 1'b1, 1'b1, 4'd6},  // R10 hit reported
    '{{11'h347, 18'h0},     1'b0, 1'b1, 1'b1, 4'd7},  // R11 hit reported
    '{{11'h7FF, 18'h0},     1'b0, 1'b0, 1'b0, 4'd0},  // R3 invalid object 0 skipped; R12 miss
    '{{11'h123, 18'h2ABCD}, 1'b0, 1'b0, 1'b1, 4'd1}   // R5 low bits ignored for standard
  };

  initial begin
    msgObj_t e;
    repeat (3) @(negedge clk);
    check(!scanDone && !matchHit && !busy && !ramRdEn && !ramWrEn && matchIdx == '0,
          "R1 reset outputs", 256'({scanDone, matchHit, busy, ramRdEn, ramWrEn, matchIdx}), 256'(0));
    rst_n = 1'b1;
    loadAll();
    check(!busy && !ramRdEn, "R1 idle after reset", 256'({busy, ramRdEn}), 256'(0));

    for (int v = 0; v < NVEC; v++) begin
      runScan(VECS[v].id, VECS[v].ide, VECS[v].rtr, 4'd1, 64'h1);
      check(matchHit == VECS[v].hit && (!VECS[v].hit || matchIdx == IDX_W'(VECS[v].idx)),
            $sformatf("R2/R3/R4 vector %0d hit/idx", v),
            256'({matchHit, matchIdx}), 256'({VECS[v].hit, IDX_W'(VECS[v].idx)}));
    end

    // Directed store tests
    loadAll();
    e = mem[1];
    runScan({11'h123, 18'h15555}, 1'b0, 1'b0, 4'd8, 64'h1122334455667788);
    e.id = stdId(11'h123); e.xtd = 1'b0; e.dlc = 4'd8; e.data = 64'h1122334455667788;
    e.newDat = 1'b1; e.txRqst = 1'b0; e.intPnd = 1'b1;
    check(mem[1] == e, "R6 R5 R8 data store into obj1", 256'(mem[1]), 256'(e));

    runScan(stdId(11'h123), 1'b0, 1'b0, 4'd4, 64'h99);
    e.dlc = 4'd4; e.data = 64'h99; e.msgLst = 1'b1;
    check(mem[1] == e, "R7 overrun sets msgLst", 256'(mem[1]), 256'(e));

    e = mem[1]; e.newDat = 1'b0; writeObj(1, e);
    runScan(stdId(11'h123), 1'b0, 1'b0, 4'd1, 64'h7);
    e.dlc = 4'd1; e.data = 64'h7; e.newDat = 1'b1;
    check(mem[1] == e, "R7 msgLst kept on clean store", 256'(mem[1]), 256'(e));

    e = mem[3];
    runScan(29'h0ABCDE12, 1'b1, 1'b0, 4'd3, 64'hF00D);
    e.id = 29'h0ABCDE12; e.xtd = 1'b1; e.dlc = 4'd3; e.data = 64'hF00D; e.newDat = 1'b1;
    check(mem[3] == e, "R8 rxIE=0 leaves intPnd", 256'(mem[3]), 256'(e));

    e = mem[5];
    runScan(stdId(11'h345), 1'b0, 1'b1, 4'd6, 64'h0);
    e.txRqst = 1'b1;
    check(mem[5] == e && matchIdx == IDX_W'(5), "R9 remote sets only txRqst", 256'(mem[5]), 256'(e));

    takeSnap();
    runScan(stdId(11'h346), 1'b0, 1'b1, 4'd2, 64'h0);
    check(matchHit && matchIdx == IDX_W'(6), "R10 dropped remote reports hit",
          256'({matchHit, matchIdx}), 256'({1'b1, IDX_W'(6)}));
    checkSnap("R10 dropped remote writes nothing");

    e = mem[7];
    runScan(stdId(11'h347), 1'b0, 1'b1, 4'd3, 64'hDEAD);
    e.id = stdId(11'h347); e.xtd = 1'b0; e.dlc = 4'd3; e.newDat = 1'b1; e.txRqst = 1'b0;
    check(mem[7] == e, "R11 remote header store", 256'(mem[7]), 256'(e));

    takeSnap();
    runScan(stdId(11'h7FF), 1'b0, 1'b0, 4'd2, 64'h1234);
    check(!matchHit, "R12 miss reports no hit", 256'(matchHit), 256'(0));
    checkSnap("R12 miss writes nothing");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule